// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Controller

This block turns simple word requests into the strobe sequence for a DRAM-style memory whose row and column addresses share one set of address pins. A requester raises the select, gives a full address, a read/write flag and write data, and holds them until the controller answers with a one-cycle done pulse. Read data arrives with that pulse. The controller puts the row half of the address on the pins with the row strobe, then the column half with the column strobe. It drives the write data or enables the memory output, and it never does both at once.

The last activated row stays open after an access. A later access to the same row goes straight to the column phase, which saves one cycle. An access to a different row first closes the open row with a one-cycle precharge. An internal timer asks for a refresh at a fixed interval. The refresh takes the next idle boundary, ahead of any waiting request. It uses the row strobe only, with the row taken from a counter that wraps. After a refresh no row is open.

The requester may withdraw the select in the cycle where done is high, or present the next request in that cycle. The memory array itself is not part of the block.

Top module: `dram_page_ctrl`

## Requirements
- R1: Reset leaves the row strobe, column strobe, output enable, data drive and done low, with no row open. While select is low at an idle boundary, no strobe changes and done stays low.
- R2: The row half (the upper ROW_W bits of the address) is placed on the memory address pins while the row strobe rises. The column half (the lower COL_W bits) is placed on the pins while the column strobe rises. The column strobe rises only when the row strobe was already high in the cycle before.
- R3: With no row open, done is high in the cycle after the fifth rising edge. The first edge that samples the request counts as edge one.
- R4: On a read (rd_wr_i = 1), the memory read/write pin is high. Output enable is high for exactly two cycles and ends with the access. Output enable and data drive are never high together.
- R5: On a write (rd_wr_i = 0), the memory read/write pin is low. The controller drives the write data for the three cycles in which the column strobe is high, and the data and the address pins stay stable through that time.
- R6: When the requested row matches the open row, the row strobe does not rise again and done appears after the fourth edge.
- R7: When a different row is open, one precharge cycle with the row strobe low comes first, and done appears after the sixth edge.
- R8: Refresh is requested every REF_INTERVAL cycles. A pending refresh is granted at the next idle boundary, ahead of a waiting request. It is a row-strobe-only cycle: three cycles with the row strobe high, then one cycle with it low, and no column strobe.
- R9: The refresh row counter starts at 0, rises by one after each refresh and wraps after 2^ROW_W rows.
- R10: After a refresh no row is open. A request that waits behind a refresh completes after 10 edges if no row was open, or 11 edges if one was open, even when it targets the row that was open before.
- R11: Done is high for exactly one cycle, and on a read rdata_o holds the word read from the memory in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cs_i | input | 1 | Request select; held until done |
| rd_wr_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | ROW_W+COL_W | Word address, row half in the upper bits |
| wdata_i | input | DATA_W | Write data |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Read data, valid with done |
| ma_o | output | max(ROW_W,COL_W) | Shared row/column address pins |
| ras_o | output | 1 | Row strobe, active high |
| cas_o | output | 1 | Column strobe, active high |
| mem_rd_wr_o | output | 1 | Memory read/write pin, 1 = read |
| oe_o | output | 1 | Memory output enable |
| dq_drv_o | output | 1 | Controller drives the data pins |
| dq_out_o | output | DATA_W | Data toward the memory |
| dq_in_i | input | DATA_W | Data from the memory |

## Verification
A due refresh and a waiting request can meet at the same idle boundary. The bench keeps its own copy of the edge count since reset. It presents a read to the still-open row in exactly the cycle where the refresh becomes pending. The result is judged at the ports. The memory model must record a row-strobe-only cycle from the expected counter row before the access's own row activation. The latency must be 11 edges rather than the 4 of a page hit, and the data must be correct. The next access to the same row must then be a page hit again.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_PRE_A,
      S_PRE_R,
      S_T1,
      S_T2,
      S_T3,
      S_T4,
      S_RF1,
      S_RF2,
      S_RF3,
      S_RF4
   } dpc_state_e;

   typedef enum logic [1:0] {
      AM_ROW,
      AM_COL,
      AM_REF
   } dpc_amux_e;

   function automatic int max_i(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dpc_refresh.sv
module dpc_refresh #(
   parameter int ROW_W        = 4,
   parameter int REF_INTERVAL = 64
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             grant_i,
   input  logic             finish_i,
   output logic             pend_o,
   output logic [ROW_W-1:0] row_o
);
   localparam int TW = $clog2(REF_INTERVAL);
   localparam logic [TW-1:0] TLAST = TW'(REF_INTERVAL - 1);

   logic [TW-1:0] tick;
   logic          wrap;

   assign wrap = (tick == TLAST);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         tick   <= '0;
         pend_o <= 1'b0;
         row_o  <= '0;
      end else begin
         tick <= wrap ? '0 : tick + 1'b1;
         if (grant_i) pend_o <= 1'b0;
         if (wrap)    pend_o <= 1'b1;
         if (finish_i) row_o <= row_o + 1'b1;
      end
   end

   p_ref_step_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      finish_i |=> row_o == ROW_W'($past(row_o) + 1'b1));

   p_pend_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      pend_o && !grant_i |=> pend_o);

endmodule

// File: rtl/dpc_page_track.sv
module dpc_page_track #(
   parameter int ROW_W     = 4,
   parameter bit PAGE_MODE = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             open_set_i,
   input  logic             open_clr_i,
   input  logic [ROW_W-1:0] new_row_i,
   input  logic [ROW_W-1:0] cmp_row_i,
   output logic             open_o,
   output logic             hit_o
);
   generate
      if (PAGE_MODE) begin : g_open_page
         logic [ROW_W-1:0] open_row;
         always_ff @(posedge clk_i) begin
            if (rst_i) begin
               open_o   <= 1'b0;
               open_row <= '0;
            end else if (open_clr_i) begin
               open_o <= 1'b0;
            end else if (open_set_i) begin
               open_o   <= 1'b1;
               open_row <= new_row_i;
            end
         end
         assign hit_o = open_o && (open_row == cmp_row_i);

         p_clear_wins_r10: assert property (@(posedge clk_i) disable iff (rst_i)
            open_clr_i |=> !open_o);
      end else begin : g_closed_page
         assign open_o = 1'b0;
         assign hit_o  = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/dpc_addr_mux.sv
module dpc_addr_mux
   import dpc_pkg::*;
#(
   parameter int ROW_W = 4,
   parameter int COL_W = 4,
   parameter int MA_W  = 4
) (
   input  dpc_amux_e        sel_i,
   input  logic [ROW_W-1:0] row_i,
   input  logic [COL_W-1:0] col_i,
   input  logic [ROW_W-1:0] ref_i,
   output logic [MA_W-1:0]  ma_o
);
   logic [MA_W-1:0] row_x, col_x, ref_x;

   generate
      if (ROW_W < MA_W) begin : g_row_pad
         assign row_x = {{(MA_W-ROW_W){1'b0}}, row_i};
         assign ref_x = {{(MA_W-ROW_W){1'b0}}, ref_i};
      end else begin : g_row_full
         assign row_x = row_i;
         assign ref_x = ref_i;
      end
      if (COL_W < MA_W) begin : g_col_pad
         assign col_x = {{(MA_W-COL_W){1'b0}}, col_i};
      end else begin : g_col_full
         assign col_x = col_i;
      end
   endgenerate

   always_comb begin
      case (sel_i)
         AM_COL:  ma_o = col_x;
         AM_REF:  ma_o = ref_x;
         default: ma_o = row_x;
      endcase
   end

endmodule

// File: rtl/dpc_seq.sv
module dpc_seq
   import dpc_pkg::*;
#(
   parameter int ROW_W  = 4,
   parameter int COL_W  = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              cs_i,
   input  logic              rd_wr_i,
   input  logic [ROW_W-1:0]  row_i,
   input  logic [COL_W-1:0]  col_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              hit_i,
   input  logic              open_i,
   input  logic              ref_pend_i,
   input  logic [DATA_W-1:0] dq_in_i,
   output logic              ras_o,
   output logic              cas_o,
   output logic              mem_rd_wr_o,
   output logic              oe_o,
   output logic              dq_drv_o,
   output logic [DATA_W-1:0] dq_out_o,
   output logic              done_o,
   output logic [DATA_W-1:0] rdata_o,
   output dpc_amux_e         amux_o,
   output logic [ROW_W-1:0]  q_row_o,
   output logic [COL_W-1:0]  q_col_o,
   output logic              open_set_o,
   output logic              open_clr_o,
   output logic              ref_grant_o,
   output logic              ref_finish_o
);
   dpc_state_e st, nxt;
   logic       q_rd;
   logic       take;
   logic       col_ph;

   assign take        = (st == S_IDLE) && !ref_pend_i && cs_i;
   assign ref_grant_o = (st == S_IDLE) && ref_pend_i;
   assign ref_finish_o = (st == S_RF4);
   assign open_set_o  = (st == S_T1);
   assign open_clr_o  = (st == S_PRE_A) || (st == S_PRE_R) || (st == S_RF1);
   assign col_ph      = (st == S_T2) || (st == S_T3) || (st == S_T4);

   always_comb begin
      nxt = st;
      case (st)
         S_IDLE: begin
            if (ref_pend_i)  nxt = open_i ? S_PRE_R : S_RF1;
            else if (cs_i)   nxt = hit_i ? S_T2 : (open_i ? S_PRE_A : S_T1);
         end
         S_PRE_A: nxt = S_T1;
         S_PRE_R: nxt = S_RF1;
         S_T1:    nxt = S_T2;
         S_T2:    nxt = S_T3;
         S_T3:    nxt = S_T4;
         S_T4:    nxt = S_IDLE;
         S_RF1:   nxt = S_RF2;
         S_RF2:   nxt = S_RF3;
         S_RF3:   nxt = S_RF4;
         S_RF4:   nxt = S_IDLE;
         default: nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         st       <= S_IDLE;
         q_row_o  <= '0;
         q_col_o  <= '0;
         q_rd     <= 1'b1;
         dq_out_o <= '0;
         done_o   <= 1'b0;
         rdata_o  <= '0;
      end else begin
         st     <= nxt;
         done_o <= (st == S_T4);
         if (take) begin
            q_row_o  <= row_i;
            q_col_o  <= col_i;
            q_rd     <= rd_wr_i;
            dq_out_o <= wdata_i;
         end
         if (st == S_T4 && q_rd) rdata_o <= dq_in_i;
      end
   end

   always_comb begin
      ras_o       = 1'b0;
      amux_o      = AM_ROW;
      case (st)
         S_IDLE:                    ras_o = open_i;
         S_T1:                      ras_o = 1'b1;
         S_T2, S_T3, S_T4: begin
            ras_o  = 1'b1;
            amux_o = AM_COL;
         end
         S_RF1, S_RF2, S_RF3: begin
            ras_o  = 1'b1;
            amux_o = AM_REF;
         end
         S_RF4:                     amux_o = AM_REF;
         default:                   ras_o = 1'b0;
      endcase
      cas_o       = col_ph;
      mem_rd_wr_o = col_ph ? q_rd : 1'b1;
      oe_o        = ((st == S_T3) || (st == S_T4)) && q_rd;
      dq_drv_o    = col_ph && !q_rd;
   end

   p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (rst_i)
      (st == S_IDLE) && !cs_i && !ref_pend_i |=> !cas_o && !done_o && (ras_o == $past(ras_o)));

   p_cas_after_ras_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(cas_o) |-> $past(ras_o));

   p_no_drive_clash_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      !(oe_o && dq_drv_o));

   p_write_stable_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      dq_drv_o && $past(dq_drv_o) |-> $stable(dq_out_o) && $stable(q_col_o));

   p_ref_first_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      (st == S_IDLE) && ref_pend_i |=> (st == S_PRE_R) || (st == S_RF1));

   p_no_cas_in_ref_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      (amux_o == AM_REF) |-> !cas_o);

   p_closed_after_ref_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      (st == S_RF4) |-> !open_i);

   p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |=> !done_o);

endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
   import dpc_pkg::*;
#(
   parameter int ROW_W        = 4,
   parameter int COL_W        = 4,
   parameter int DATA_W       = 8,
   parameter int REF_INTERVAL = 64,
   parameter bit PAGE_MODE    = 1'b1,
   localparam int ADDR_W      = ROW_W + COL_W,
   localparam int MA_W        = max_i(ROW_W, COL_W)
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              cs_i,
   input  logic              rd_wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              done_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic [MA_W-1:0]   ma_o,
   output logic              ras_o,
   output logic              cas_o,
   output logic              mem_rd_wr_o,
   output logic              oe_o,
   output logic              dq_drv_o,
   output logic [DATA_W-1:0] dq_out_o,
   input  logic [DATA_W-1:0] dq_in_i
);
   if (ROW_W < 1 || COL_W < 1 || DATA_W < 1) begin : g_bad_width
      initial $fatal(1, "dram_page_ctrl: widths must be positive");
   end
   if (REF_INTERVAL < 16) begin : g_bad_interval
      initial $fatal(1, "dram_page_ctrl: refresh interval too short");
   end

   logic [ROW_W-1:0] in_row, q_row, ref_row;
   logic [COL_W-1:0] in_col, q_col;
   logic             hit, open_v, ref_pend;
   logic             open_set, open_clr, ref_grant, ref_finish;
   dpc_amux_e        amux;

   assign in_row = addr_i[ADDR_W-1:COL_W];
   assign in_col = addr_i[COL_W-1:0];

   dpc_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_seq (
      .clk_i(clk_i), .rst_i(rst_i), .cs_i(cs_i), .rd_wr_i(rd_wr_i),
      .row_i(in_row), .col_i(in_col), .wdata_i(wdata_i),
      .hit_i(hit), .open_i(open_v), .ref_pend_i(ref_pend), .dq_in_i(dq_in_i),
      .ras_o(ras_o), .cas_o(cas_o), .mem_rd_wr_o(mem_rd_wr_o), .oe_o(oe_o),
      .dq_drv_o(dq_drv_o), .dq_out_o(dq_out_o), .done_o(done_o), .rdata_o(rdata_o),
      .amux_o(amux), .q_row_o(q_row), .q_col_o(q_col),
      .open_set_o(open_set), .open_clr_o(open_clr),
      .ref_grant_o(ref_grant), .ref_finish_o(ref_finish)
   );

   dpc_page_track #(.ROW_W(ROW_W), .PAGE_MODE(PAGE_MODE)) u_track (
      .clk_i(clk_i), .rst_i(rst_i), .open_set_i(open_set), .open_clr_i(open_clr),
      .new_row_i(q_row), .cmp_row_i(in_row), .open_o(open_v), .hit_o(hit)
   );

   dpc_refresh #(.ROW_W(ROW_W), .REF_INTERVAL(REF_INTERVAL)) u_ref (
      .clk_i(clk_i), .rst_i(rst_i), .grant_i(ref_grant), .finish_i(ref_finish),
      .pend_o(ref_pend), .row_o(ref_row)
   );

   dpc_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .MA_W(MA_W)) u_amux (
      .sel_i(amux), .row_i(q_row), .col_i(q_col), .ref_i(ref_row), .ma_o(ma_o)
   );

   p_addr_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      dq_drv_o && $past(dq_drv_o) |-> $stable(ma_o));

endmodule

// File: tb/tb_dram_page_ctrl.sv
module tb_dram_page_ctrl;
   localparam int RW = 4, CW = 4, DW = 8, RI = 64;

   logic          clk = 1'b0, rst = 1'b1;
   logic          cs = 1'b0, rd_wr = 1'b1;
   logic [7:0]    addr = '0;
   logic [DW-1:0] wdata = '0;
   logic          done, ras, cas, mem_rw, oe, drv;
   logic [DW-1:0] rdata, dq_out, dq_in;
   logic [3:0]    ma;

   always #2 clk = ~clk;

   dram_page_ctrl #(.ROW_W(RW), .COL_W(CW), .DATA_W(DW), .REF_INTERVAL(RI)) dut (
      .clk_i(clk), .rst_i(rst), .cs_i(cs), .rd_wr_i(rd_wr), .addr_i(addr),
      .wdata_i(wdata), .done_o(done), .rdata_o(rdata), .ma_o(ma), .ras_o(ras),
      .cas_o(cas), .mem_rd_wr_o(mem_rw), .oe_o(oe), .dq_drv_o(drv),
      .dq_out_o(dq_out), .dq_in_i(dq_in)
   );

   // behavioural memory array
   logic [DW-1:0] mem [256];
   logic [3:0]    m_row = '0, m_col = '0, exp_ref_row = '0, last_act_row = '0;
   logic          ras_q = 1'b0, cas_q = 1'b0, cas_seen = 1'b0;
   int            ras_rises = 0, refreshes = 0, ref_bad = 0, wr_nodrv = 0;
   int            cyc = 0;

   assign dq_in = oe ? mem[{m_row, m_col}] : '0;

   always @(posedge clk) begin
      if (rst) cyc <= 0; else cyc <= cyc + 1;
      ras_q <= ras;
      cas_q <= cas;
      if (ras && !ras_q) begin
         m_row <= ma;
         last_act_row <= ma;
         ras_rises <= ras_rises + 1;
      end
      if (cas && !cas_q) begin
         m_col <= ma;
         cas_seen <= 1'b1;
         if (!mem_rw) begin
            mem[{m_row, ma}] <= dq_out;
            if (!drv) wr_nodrv <= wr_nodrv + 1;
         end
      end
      if (!ras && ras_q) begin
         if (!cas_seen) begin
            refreshes <= refreshes + 1;
            if (m_row != exp_ref_row) ref_bad <= ref_bad + 1;
            exp_ref_row <= exp_ref_row + 1'b1;
         end
         cas_seen <= 1'b0;
      end
   end

   int  checks = 0, errors = 0;
   bit  finished = 1'b0;
   logic       exp_open = 1'b0;
   logic [3:0] exp_row = '0;
   int         known_refs = 0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   task automatic sync_refs();
      if (refreshes != known_refs) begin
         exp_open   = 1'b0;
         known_refs = refreshes;
      end
   endtask

   task automatic wait_safe(input int n);
      @(negedge clk);
      while (!((cyc % RI) >= 16 && (cyc % RI) + n < RI - 2)) @(negedge clk);
      sync_refs();
   endtask

   // one request; returns latency in edges and per-cycle observations
   task automatic access(input logic rd, input logic [7:0] a, input logic [7:0] wd,
                         output logic [7:0] got, output int lat,
                         output int oe_n, output int drv_n);
      cs = 1'b1; rd_wr = rd; addr = a; wdata = wd;
      lat = 0; oe_n = 0; drv_n = 0; got = '0;
      while (lat < 40) begin
         @(negedge clk);
         lat++;
         if (oe) oe_n++;
         if (drv) drv_n++;
         if (done) begin
            got = rdata;
            cs = 1'b0;
            break;
         end
      end
      @(negedge clk);
      check("R11 done lasts one cycle", 32'(done), 32'd0);
      exp_open = 1'b1;
      exp_row  = a[7:4];
   endtask

   function automatic int exp_lat(input logic [7:0] a);
      if (exp_open && exp_row == a[7:4]) return 4;
      if (exp_open) return 6;
      return 5;
   endfunction

   task automatic t_reset();
      @(negedge clk);
      check("R1 reset ras", 32'(ras), 0);
      check("R1 reset cas", 32'(cas), 0);
      check("R1 reset oe/drive", 32'({oe, drv}), 0);
      check("R1 reset done", 32'(done), 0);
   endtask

   task automatic t_cs_low();
      int r0;
      int seen;
      wait_safe(14);
      r0 = ras_rises; seen = 0;
      cs = 1'b0; rd_wr = 1'b0; addr = 8'h9C; wdata = 8'h11;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (done || cas) seen++;
      end
      check("R1 select low gives no done/cas", 32'(seen), 0);
      check("R1 select low gives no row strobe", 32'(ras_rises - r0), 0);
   endtask

   task automatic t_miss_write(input logic [7:0] a, input logic [7:0] d, input string tag);
      logic [7:0] got; int lat, on, dn, r0, el;
      wait_safe(12);
      el = exp_lat(a); r0 = ras_rises;
      access(1'b0, a, d, got, lat, on, dn);
      check({tag, " write latency"}, 32'(lat), 32'(el));
      check("R5 write drive cycles", 32'(dn), 3);
      check("R4 no output enable on write", 32'(on), 0);
      check("R5 word stored", 32'(mem[a]), 32'(d));
      check("R5 drive at column strobe", 32'(wr_nodrv), 0);
      if (el != 4) begin
         check("R2 row half captured with row strobe", 32'(last_act_row), 32'(a[7:4]));
         check({tag, " one activation"}, 32'(ras_rises - r0), 1);
      end else
         check("R6 no new row strobe on hit", 32'(ras_rises - r0), 0);
   endtask

   task automatic t_read(input logic [7:0] a, input string tag);
      logic [7:0] got; int lat, on, dn, el, r0;
      wait_safe(12);
      el = exp_lat(a); r0 = ras_rises;
      access(1'b1, a, 8'h00, got, lat, on, dn);
      check({tag, " read latency"}, 32'(lat), 32'(el));
      check("R11 read data with done", 32'(got), 32'(mem[a]));
      check("R4 output enable cycles", 32'(on), 2);
      check("R4 no drive on read", 32'(dn), 0);
      if (el == 4) check("R6 hit keeps row strobe", 32'(ras_rises - r0), 0);
   endtask

   task automatic t_refresh_first();
      logic [7:0] got; int lat, on, dn, f0, r0, el;
      wait_safe(10);
      access(1'b1, 8'h35, 8'h00, got, lat, on, dn);
      while ((cyc % RI) != 0) @(negedge clk);
      el = exp_open ? 11 : 10;
      f0 = refreshes; r0 = ras_rises;
      access(1'b1, 8'h35, 8'h00, got, lat, on, dn);
      check("R8 refresh before waiting request", 32'(refreshes - f0), 1);
      check("R10 latency behind refresh", 32'(lat), 32'(el));
      check("R10 same row re-activated", 32'(ras_rises - r0), 2);
      check("R10 data after refresh", 32'(got), 32'(mem[8'h35]));
      known_refs = refreshes;
      exp_open = 1'b1; exp_row = 4'h3;
      t_read(8'h3C, "R6 hit after refresh");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_cs_low();
      t_miss_write(8'h35, 8'hA5, "R3");
      t_read(8'h35, "R6");
      t_miss_write(8'h3C, 8'h5A, "R6");
      t_miss_write(8'h71, 8'h0F, "R7");
      t_read(8'h3C, "R7");
      t_read(8'h35, "R6");
      t_miss_write(8'hE2, 8'hC3, "R7");
      t_read(8'hE2, "R6");
      t_refresh_first();
      repeat (20 * RI) @(negedge clk);
      check("R9 refresh count covers wrap", 32'(refreshes > 17), 1);
      check("R9 refresh rows in counter order", 32'(ref_bad), 0);
      check("R8 refresh has no column strobe", 32'(cas), 0);
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

endmodule